// File: doc/BRIEF.md
# Byte-Strobed EDO DRAM Control Front End

This block is a clocked, synthesizable device model of the control front end of a 16-bit EDO DRAM with two byte strobes. Its array is scaled down so that it can be simulated. It oversamples the active-low row strobe, the two active-low column strobes (lower byte and upper byte), write enable, output enable and a 9-bit multiplexed address. It finds the edges of these signals and decides what each memory cycle is: a read, an early write, a late write (read-modify-write), a refresh that only uses the row strobe, or a refresh where a column strobe falls before the row strobe. A test bench uses it as the memory on the far side of a DRAM controller under test.

The two column strobes are merged into one internal strobe. That strobe becomes active on the first lane to fall and inactive only once both lanes are high. Each byte lane still gates its own output drivers and its own write. An internal 9-bit row counter supplies the row for strobe-ordered refreshes. Every refreshed row has its age tracked against a configured limit, and a sticky flag shows when any row has been neglected.

Top module: `edo_dram_front`

## Requirements
- R1: `col_strobe` is 1 in the cycle after either column strobe is sampled low. It returns to 0 only in the cycle after both are sampled high. The column address is captured at the first lane's fall, and a lane that falls later in the same strobe period uses that column.
- R2: The lower column strobe governs bits 7:0 (`dq_oe[0]`), and the upper column strobe governs bits 15:8 (`dq_oe[1]`), for both read driving and byte writes.
- R3: A row-strobe fall sampled while either column strobe is low is a counter refresh. `cyc_kind` becomes 5, `cbr_row` increments by one (wrapping at 9 bits), `dq_oe` stays 0 and the array is unchanged.
- R4: A row-strobe fall with both column strobes high opens the addressed row. If no column strobe follows, `cyc_kind` reads 4, nothing is driven and the array is unchanged.
- R5: If write enable is low when the first column strobe falls, the cycle is an early write. `cyc_kind` becomes 2, the input word is written to the lanes that fell, and `dq_oe` stays 0 for the whole cycle.
- R6: If write enable falls while a read is in progress with a column strobe low, the cycle becomes a late write. `cyc_kind` becomes 3, the lanes that are low are written, and driving stops.
- R7: A lane drives (`dq_oe` bit 1) only if its strobe fell in a read, write enable is high and output enable is low. Raising output enable releases the lane at once, without waiting for a clock.
- R8: When the row strobe and both column strobes are sampled high, `dq_oe` is 0 from the next cycle on.
- R9: While the row stays open, read data stays driven after the column strobes rise. It changes only at the next column-strobe fall, which loads the new column.
- R10: Every row-strobe fall refreshes its row. `refresh_stale` sets once any modelled row has gone more than REFRESH_LIMIT cycles since its last refresh, and it holds until reset.
- R11: After reset, `dq_oe`=0, `cyc_kind`=0, `cbr_row`=0, `col_strobe`=0, `refresh_stale`=0 and every array word is zero.
- R12: Row or column addresses at or beyond the modelled array size are ignored for writes and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-byte output enable (bit 0 = bits 7:0) |
| col_strobe | output | 1 | Merged internal column strobe, active high |
| cyc_kind | output | 3 | Kind of the latest cycle: 0 none, 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 counter refresh |
| cbr_row | output | 9 | Internal refresh row counter |
| refresh_stale | output | 1 | Sticky flag: a row exceeded the refresh limit |

## Verification
A wrong merge state shows up on `col_strobe` one sample after the lane edge. It also shows up later as the wrong byte or column on `dq_out` in the next read. A mistaken cycle kind appears on `cyc_kind` in the cycle after the edge that decided it. It also shows up as a bus driven during a write or refresh, or as a stored word that a later read-back exposes. A refresh counter that skips or stalls is visible on `cbr_row` immediately. A wrong age record only becomes visible at the ports once the configured limit has passed.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DQ_W   = LANES * LANE_W;
    localparam int ADDR_W = 9;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_READ   = 3'd1,
        KIND_EWRITE = 3'd2,
        KIND_LWRITE = 3'd3,
        KIND_RASREF = 3'd4,
        KIND_CBR    = 3'd5
    } cyc_kind_e;
endpackage

// File: rtl/edo_strobe_merge.sv
`timescale 1ns/1ps
module edo_strobe_merge
    import edo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_n,
    output logic [LANES-1:0] lane_low,
    output logic [LANES-1:0] lane_fall,
    output logic             any_low,
    output logic             first_fall,
    output logic             strobe_q
);
    typedef struct packed {
        logic [LANES-1:0] prev_n;
        logic             strobe;
    } mrg_t;

    mrg_t st_d, st_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_low[i]  = ~lane_n[i];
        assign lane_fall[i] = st_q.prev_n[i] & ~lane_n[i];
    end

    assign any_low    = |lane_low;
    assign first_fall = (&st_q.prev_n) & any_low;
    assign strobe_q   = st_q.strobe;

    always_comb begin
        st_d        = st_q;
        st_d.prev_n = lane_n;
        if (any_low) begin
            st_d.strobe = 1'b1;
        end else if (&lane_n) begin
            st_d.strobe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{prev_n: '1, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/edo_cell_array.sv
`timescale 1ns/1ps
module edo_cell_array
    import edo_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ROW_W+COL_W-1:0] rd_idx,
    input  logic [ROW_W+COL_W-1:0] wr_idx,
    input  logic [LANES-1:0]       wr_lane,
    input  logic [DQ_W-1:0]        wr_data,
    output logic [DQ_W-1:0]        rd_data
);
    localparam int DEPTH = 1 << (ROW_W + COL_W);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int k = 0; k < DEPTH; k++) begin
                    cells[k] <= '0;
                end
            end else if (wr_lane[l]) begin
                cells[wr_idx] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        assign rd_data[l*LANE_W +: LANE_W] = cells[rd_idx];
    end
endmodule

// File: rtl/edo_refresh_age.sv
`timescale 1ns/1ps
module edo_refresh_age
    import edo_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int LIMIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_ev,
    input  logic [ADDR_W-1:0] ref_row,
    output logic              stale
);
    localparam int ROWS = 1 << ROW_W;
    localparam int AW   = $clog2(LIMIT + 2);
    localparam logic [AW-1:0] LIM_V = AW'(LIMIT);
    localparam logic [AW-1:0] SAT_V = AW'(LIMIT + 1);

    typedef struct packed {
        logic [ROWS-1:0][AW-1:0] age;
        logic                    stale;
    } age_t;

    age_t ag_d, ag_q;

    always_comb begin
        ag_d = ag_q;
        for (int r = 0; r < ROWS; r++) begin
            if (ref_ev && ref_row == ADDR_W'(r)) begin
                ag_d.age[r] = '0;
            end else if (ag_q.age[r] < SAT_V) begin
                ag_d.age[r] = ag_q.age[r] + 1'b1;
            end
            if (ag_q.age[r] > LIM_V) begin
                ag_d.stale = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ag_q <= '0;
        end else begin
            ag_q <= ag_d;
        end
    end

    assign stale = ag_q.stale;
endmodule

// File: rtl/edo_dram_front.sv
`timescale 1ns/1ps
module edo_dram_front
    import edo_pkg::*;
#(
    parameter int ROW_W         = 3,
    parameter int COL_W         = 3,
    parameter int REFRESH_LIMIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic              col_strobe,
    output logic [2:0]        cyc_kind,
    output logic [ADDR_W-1:0] cbr_row,
    output logic              refresh_stale
);
    localparam int IDX_W = ROW_W + COL_W;

    typedef struct packed {
        logic              ras_p;
        logic              we_p;
        logic              act;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        cyc_kind_e         kind;
        logic [LANES-1:0]  drv;
        logic [DQ_W-1:0]   dout;
        logic [ADDR_W-1:0] rfc;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [LANES-1:0]  lane_low, lane_fall, wr_lane;
    logic              any_low, first_fall, strobe_q;
    logic [ADDR_W-1:0] col_sel, ref_row;
    logic              ref_ev, ras_fall, ras_rise, addr_ok;
    logic [IDX_W-1:0]  cell_idx;
    logic [DQ_W-1:0]   rd_data;

    edo_strobe_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_n     ({ucas_n, lcas_n}),
        .lane_low   (lane_low),
        .lane_fall  (lane_fall),
        .any_low    (any_low),
        .first_fall (first_fall),
        .strobe_q   (strobe_q)
    );

    edo_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (cell_idx),
        .wr_idx  (cell_idx),
        .wr_lane (wr_lane),
        .wr_data (dq_in),
        .rd_data (rd_data)
    );

    edo_refresh_age #(.ROW_W(ROW_W), .LIMIT(REFRESH_LIMIT)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_ev  (ref_ev),
        .ref_row (ref_row),
        .stale   (refresh_stale)
    );

    assign ras_fall = ~ras_n & c_q.ras_p;
    assign ras_rise = ras_n & ~c_q.ras_p;
    assign col_sel  = first_fall ? addr : c_q.col;
    assign cell_idx = {c_q.row[ROW_W-1:0], col_sel[COL_W-1:0]};
    assign addr_ok  = (c_q.row[ADDR_W-1:ROW_W] == '0) && (col_sel[ADDR_W-1:COL_W] == '0);

    always_comb begin
        c_d       = c_q;
        c_d.ras_p = ras_n;
        c_d.we_p  = we_n;
        wr_lane   = '0;
        ref_ev    = 1'b0;
        ref_row   = addr;

        if (ras_fall) begin
            ref_ev = 1'b1;
            if (any_low) begin
                c_d.kind = KIND_CBR;
                ref_row  = c_q.rfc;
                c_d.rfc  = c_q.rfc + 1'b1;
                c_d.act  = 1'b0;
            end else begin
                c_d.act  = 1'b1;
                c_d.row  = addr;
                c_d.kind = KIND_RASREF;
            end
        end
        if (ras_rise) begin
            c_d.act = 1'b0;
        end

        if (c_q.act && !ras_n) begin
            if (first_fall) begin
                c_d.col  = addr;
                c_d.kind = we_n ? KIND_READ : KIND_EWRITE;
            end
            for (int i = 0; i < LANES; i++) begin
                if (lane_fall[i]) begin
                    if (!we_n) begin
                        wr_lane[i] = addr_ok;
                    end else begin
                        c_d.dout[i*LANE_W +: LANE_W] =
                            addr_ok ? rd_data[i*LANE_W +: LANE_W] : '0;
                        c_d.drv[i] = 1'b1;
                    end
                end
            end
            if (!we_n && c_q.we_p && !first_fall && any_low &&
                (c_q.kind == KIND_READ || c_q.kind == KIND_LWRITE)) begin
                c_d.kind = KIND_LWRITE;
                wr_lane  = lane_low & {LANES{addr_ok}};
                c_d.drv  = '0;
            end
        end

        if (ras_n && !any_low) begin
            c_d.drv = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{ras_p: 1'b1, we_p: 1'b1, act: 1'b0, row: '0, col: '0,
                     kind: KIND_NONE, drv: '0, dout: '0, rfc: '0};
        end else begin
            c_q <= c_d;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_oe
        assign dq_oe[i] = c_q.drv[i] & ~oe_n & we_n;
    end

    assign dq_out     = c_q.dout;
    assign col_strobe = strobe_q;
    assign cyc_kind   = c_q.kind;
    assign cbr_row    = c_q.rfc;
endmodule

// File: rtl/edo_dram_front_chk.sv
`timescale 1ns/1ps
module edo_dram_front_chk
    import edo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic              lcas_n,
    input logic              ucas_n,
    input logic [LANES-1:0]  dq_oe,
    input logic              col_strobe,
    input logic [2:0]        cyc_kind,
    input logic [ADDR_W-1:0] cbr_row,
    input logic              refresh_stale
);
    logic ras_prev;
    logic ras_fall_c;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev <= 1'b1;
        end else begin
            ras_prev <= ras_n;
        end
    end

    assign ras_fall_c = ras_prev & ~ras_n;

    AST_STROBE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcas_n || !ucas_n) |=> col_strobe); // R1

    AST_STROBE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (lcas_n && ucas_n) |=> !col_strobe); // R1

    AST_CBR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall_c && (!lcas_n || !ucas_n)) |=>
            (cbr_row == ADDR_W'($past(cbr_row) + 1'b1) && cyc_kind == KIND_CBR)); // R3

    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && lcas_n && ucas_n) |=> (dq_oe == '0)); // R8

    AST_STALE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stale |=> refresh_stale); // R10
endmodule

bind edo_dram_front edo_dram_front_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ras_n         (ras_n),
    .lcas_n        (lcas_n),
    .ucas_n        (ucas_n),
    .dq_oe         (dq_oe),
    .col_strobe    (col_strobe),
    .cyc_kind      (cyc_kind),
    .cbr_row       (cbr_row),
    .refresh_stale (refresh_stale)
);

// File: tb/edo_dram_front_tb.sv
`timescale 1ns/1ps
module edo_dram_front_tb;
    import edo_pkg::*;

    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int LIMIT = 200;
    localparam int NROW  = 1 << ROW_W;
    localparam int NCOL  = 1 << COL_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n, ras_n, lcas_n, ucas_n, we_n, oe_n;
    logic [ADDR_W-1:0] addr;
    logic [DQ_W-1:0]   dq_in, dq_out;
    logic [LANES-1:0]  dq_oe;
    logic              col_strobe, refresh_stale;
    logic [2:0]        cyc_kind;
    logic [ADDR_W-1:0] cbr_row;

    edo_dram_front #(.ROW_W(ROW_W), .COL_W(COL_W), .REFRESH_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .col_strobe(col_strobe), .cyc_kind(cyc_kind),
        .cbr_row(cbr_row), .refresh_stale(refresh_stale)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [15:0] model [NROW*NCOL];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_idle();
        ras_n = 1'b1; lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic do_reset();
        bus_idle();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        for (int k = 0; k < NROW*NCOL; k++) model[k] = '0;
    endtask

    function automatic logic [15:0] pat(input int r, input int c);
        return 16'((r * NCOL + c) * 16'h0457) ^ 16'hA5C3;
    endfunction

    task automatic ras_only(input int r);
        addr = ADDR_W'(r); ras_n = 1'b0; tick();
        ras_n = 1'b1; tick();
    endtask

    task automatic ewrite(input int r, input int c, input logic [15:0] data, input logic [1:0] lanes);
        addr = ADDR_W'(r); ras_n = 1'b0; tick();
        addr = ADDR_W'(c); we_n = 1'b0; dq_in = data;
        lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; oe_n = 1'b0; tick();
        check("R5 early write keeps bus open", dq_oe, 0);
        check("R5 early write kind", cyc_kind, 2);
        lcas_n = 1'b1; ucas_n = 1'b1; we_n = 1'b1; tick();
        check("R5 bus open after strobes rise", dq_oe, 0);
        ras_n = 1'b1; oe_n = 1'b1; tick();
        if (r < NROW && c < NCOL) begin
            if (lanes[0]) model[r*NCOL+c][7:0]  = data[7:0];
            if (lanes[1]) model[r*NCOL+c][15:8] = data[15:8];
        end
    endtask

    task automatic read_chk(input int r, input int c, input logic [1:0] lanes, input string req);
        logic [15:0] mask, exp;
        mask = {{8{lanes[1]}}, {8{lanes[0]}}};
        exp  = (r < NROW && c < NCOL) ? model[r*NCOL+c] : 16'h0000;
        addr = ADDR_W'(r); ras_n = 1'b0; tick();
        addr = ADDR_W'(c); oe_n = 1'b0; lcas_n = ~lanes[0]; ucas_n = ~lanes[1]; tick();
        check({req, " read data"}, dq_out & mask, exp & mask);
        check({req, " lane drive"}, dq_oe, lanes);
        lcas_n = 1'b1; ucas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; tick(2);
    endtask

    initial begin
        dq_in = '0; addr = '0;
        do_reset();

        // R11 reset state
        check("R11 dq_oe", dq_oe, 0);
        check("R11 cyc_kind", cyc_kind, 0);
        check("R11 cbr_row", cbr_row, 0);
        check("R11 col_strobe", col_strobe, 0);
        check("R11 refresh_stale", refresh_stale, 0);

        // R10 refresh age tracking
        for (int r = 0; r < NROW; r++) ras_only(r);
        tick(150);
        check("R10 no stale within limit", refresh_stale, 0);
        for (int r = 0; r < NROW; r++) ras_only(r);
        check("R10 no stale after second sweep", refresh_stale, 0);
        tick(LIMIT + 30);
        check("R10 stale after neglect", refresh_stale, 1);
        tick(5);
        check("R10 stale sticky", refresh_stale, 1);

        do_reset();
        check("R11 stale cleared by reset", refresh_stale, 0);
        read_chk(3, 5, 2'b11, "R11 array zero");

        // R1 strobe merge with RAS high
        lcas_n = 1'b0; tick();
        check("R1 first fall lower", col_strobe, 1);
        ucas_n = 1'b0; tick();
        lcas_n = 1'b1; tick();
        check("R1 held until last rise", col_strobe, 1);
        ucas_n = 1'b1; tick();
        check("R1 released after last rise", col_strobe, 0);
        ucas_n = 1'b0; tick();
        check("R1 first fall upper", col_strobe, 1);
        ucas_n = 1'b1; tick(2);

        // R5 / R2 / R7 sweep of the whole array
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                ewrite(r, c, pat(r, c), 2'b11);
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++)
                read_chk(r, c, 2'b11, "R7 sweep");

        // R2 byte lanes
        ewrite(1, 1, 16'hBEEF, 2'b01);
        ewrite(6, 2, 16'h7A11, 2'b10);
        read_chk(1, 1, 2'b11, "R2 lower-only write");
        read_chk(6, 2, 2'b11, "R2 upper-only write");
        read_chk(1, 1, 2'b10, "R2 upper-only read");
        read_chk(6, 2, 2'b01, "R2 lower-only read");

        // R1 column captured at first lane fall
        addr = 9'd2; ras_n = 1'b0; tick();
        addr = 9'd4; oe_n = 1'b0; lcas_n = 1'b0; tick();
        addr = 9'd6; ucas_n = 1'b0; tick();
        check("R1 late lane uses first-fall column", dq_out, model[2*NCOL+4]);
        check("R1 both lanes drive", dq_oe, 2'b11);
        bus_idle(); tick(2);

        // R7 output enable release, R9 extended data, R8 standby
        addr = 9'd5; ras_n = 1'b0; tick();
        addr = 9'd0; oe_n = 1'b0; lcas_n = 1'b0; ucas_n = 1'b0; tick();
        check("R9 first column data", dq_out, model[5*NCOL+0]);
        oe_n = 1'b1; #1;
        check("R7 OE high releases", dq_oe, 0);
        oe_n = 1'b0; #1;
        check("R7 OE low re-drives", dq_oe, 2'b11);
        tick();
        lcas_n = 1'b1; ucas_n = 1'b1; addr = 9'd7; tick();
        check("R9 drive held after strobe rise", dq_oe, 2'b11);
        check("R9 data held after strobe rise", dq_out, model[5*NCOL+0]);
        lcas_n = 1'b0; ucas_n = 1'b0; tick();
        check("R9 data changes at next fall", dq_out, model[5*NCOL+7]);
        lcas_n = 1'b1; ucas_n = 1'b1; tick();
        check("R8 still driven with row open", dq_oe, 2'b11);
        ras_n = 1'b1; tick();
        check("R8 standby high-Z", dq_oe, 0);
        oe_n = 1'b1; tick();

        // R6 late write
        addr = 9'd3; ras_n = 1'b0; tick();
        addr = 9'd2; lcas_n = 1'b0; ucas_n = 1'b0; tick();
        check("R6 starts as read", cyc_kind, 1);
        dq_in = 16'h5A3C; we_n = 1'b0; tick();
        check("R6 late write kind", cyc_kind, 3);
        check("R6 no drive during write", dq_oe, 0);
        bus_idle(); tick(2);
        model[3*NCOL+2] = 16'h5A3C;
        read_chk(3, 2, 2'b11, "R6 late write stored");

        // R4 row-only refresh
        oe_n = 1'b0; addr = 9'd3; ras_n = 1'b0; tick();
        check("R4 kind", cyc_kind, 4);
        check("R4 no drive", dq_oe, 0);
        bus_idle(); tick();
        read_chk(3, 2, 2'b11, "R4 array unchanged");

        // R3 counter refresh
        for (int k = 0; k < 3; k++) begin
            oe_n = 1'b0;
            if (k == 1) ucas_n = 1'b0; else lcas_n = 1'b0;
            tick();
            ras_n = 1'b0; tick();
            check("R3 kind", cyc_kind, 5);
            check("R3 bus high-Z", dq_oe, 0);
            check("R3 counter step", cbr_row, k + 1);
            ras_n = 1'b1; tick();
            bus_idle(); tick();
        end
        read_chk(3, 2, 2'b11, "R3 array unchanged");

        // R12 out-of-range addresses
        ewrite(8, 0, 16'hDEAD, 2'b11);
        read_chk(0, 0, 2'b11, "R12 wrapped row not written");
        read_chk(8, 0, 2'b11, "R12 out-of-range read zero");
        ewrite(0, 9, 16'hFACE, 2'b11);
        read_chk(0, 1, 2'b11, "R12 wrapped column not written");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule